// File: doc/BRIEF.md
# Software Interrupt Trigger Register

This block turns a single 32-bit write from a CPU into software interrupts on one or more CPU interfaces. The written word holds a 4-bit interrupt number (0 to 15), an 8-bit bitmap of destination CPU interfaces and a 2-bit routing mode. The routing mode picks the destination set. It is either the CPUs named in the bitmap, every CPU except the writer, or the writer alone. The number of the CPU doing the write comes in on its own port.

Each destination gets its pending bit for the chosen interrupt number set in a per-CPU, per-number pending array. The array is exposed to the CPU interfaces. A pending bit stays set until the owning CPU interface acknowledges that number with its own clear strobe. Software interrupts behave like edges: writing again to a bit that is already pending changes nothing.

Top module: `sgi_trigger`

## Requirements
- R1: After reset every bit of `pend_o` is 0. Bit `c*NUM_ID + n` is the pending flag of interrupt number n on CPU c.
- R2: The interrupt number is taken from `wr_data_i[3:0]`, the destination bitmap from `wr_data_i[23:16]` and the routing mode from `wr_data_i[25:24]`.
- R3: Mode 00 (list) marks pending only on CPUs whose bit is set in the bitmap. Bitmap bits at or above `NUM_CPU` select nothing.
- R4: Mode 01 (others) marks pending on every CPU except `wr_cpu_i`, whatever the bitmap holds.
- R5: Mode 10 (self) marks pending only on `wr_cpu_i`, whatever the bitmap holds.
- R6: Mode 11 is reserved. A write in this mode leaves `pend_o` unchanged.
- R7: A list-mode write whose bitmap selects no existing CPU leaves `pend_o` unchanged.
- R8: A pending bit rises on the first clock edge after the write is accepted. It stays 1 across further writes and idle cycles until it is cleared.
- R9: A clear strobe on `ack_vld_i[c]` with number `ack_id_i[4c+3:4c]` drops only that CPU's bit for that number, one edge later.
- R10: When a write and a clear hit the same bit in the same cycle, the bit ends up 1 (the new trigger wins).
- R11: Bits [15:4] and [31:26] of the written word have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Write strobe for the trigger register |
| wr_cpu_i | input | CPU_W | Number of the writing CPU |
| wr_data_i | input | 32 | Written word |
| ack_vld_i | input | NUM_CPU | Per-CPU clear strobe |
| ack_id_i | input | 4*NUM_CPU | Per-CPU interrupt number to clear |
| pend_o | output | NUM_CPU*NUM_ID | Pending array, CPU-major |

## Verification
Every result of this block lands one edge after its stimulus. A write or a clear that is present in cycle k shows in `pend_o` right after edge k+1, and there is no other latency. The bench drives inputs on the falling edge and lets one rising edge pass. It compares the whole pending array with its own model on the next falling edge, so each comparison sees exactly the state produced by that one stimulus. The sweep covers every writer, every mode and several bitmaps. Between cases a full clear pass returns the array to zero, so no case depends on the one before it.

// File: rtl/sgi_pkg.sv
package sgi_pkg;

  typedef enum logic [1:0] {
    ROUTE_LIST   = 2'b00,
    ROUTE_OTHERS = 2'b01,
    ROUTE_SELF   = 2'b10,
    ROUTE_RSVD   = 2'b11
  } route_e;

  localparam int NUM_W   = 4;
  localparam int NUM_LSB = 0;
  localparam int MAP_W   = 8;
  localparam int MAP_LSB = 16;
  localparam int RTE_LSB = 24;

  function automatic logic [NUM_W-1:0] word_num(input logic [31:0] w);
    return w[NUM_LSB +: NUM_W];
  endfunction

  function automatic logic [MAP_W-1:0] word_map(input logic [31:0] w);
    return w[MAP_LSB +: MAP_W];
  endfunction

  function automatic route_e word_route(input logic [31:0] w);
    return route_e'(w[RTE_LSB +: 2]);
  endfunction

endpackage

// File: rtl/sgi_route_dec.sv
module sgi_route_dec
  import sgi_pkg::*;
#(
  parameter int NUM_CPU = 4,
  parameter int CPU_W   = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en_i,
  input  logic [CPU_W-1:0]   wr_cpu_i,
  input  logic [31:0]        wr_data_i,
  output logic [NUM_CPU-1:0] dest_o,
  output logic [NUM_W-1:0]   num_o,
  output logic               fire_o
);

  route_e             route;
  logic [MAP_W-1:0]   map;
  logic               unused_word;

  assign route       = word_route(wr_data_i);
  assign map         = word_map(wr_data_i);
  assign num_o       = word_num(wr_data_i);
  assign unused_word = ^wr_data_i;

  always_comb begin
    for (int c = 0; c < NUM_CPU; c++) begin
      unique case (route)
        ROUTE_LIST:   dest_o[c] = map[c];
        ROUTE_OTHERS: dest_o[c] = (wr_cpu_i != CPU_W'(c));
        ROUTE_SELF:   dest_o[c] = (wr_cpu_i == CPU_W'(c));
        default:      dest_o[c] = 1'b0;
      endcase
    end
  end

  assign fire_o = wr_en_i && (|dest_o);

  AST_RSVD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (route == ROUTE_RSVD) |-> (dest_o == '0)); // R6

  AST_LIST_SUBSET: assert property (@(posedge clk) disable iff (!rst_n)
    (route == ROUTE_LIST) |-> ((dest_o & ~map[NUM_CPU-1:0]) == '0)); // R3

  AST_SELF_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (route == ROUTE_SELF) |-> $onehot0(dest_o)); // R5

  AST_OTHERS_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
    (route == ROUTE_OTHERS && int'(wr_cpu_i) < NUM_CPU) |-> !dest_o[wr_cpu_i]); // R4

endmodule

// File: rtl/sgi_pend_bank.sv
module sgi_pend_bank #(
  parameter int BITS = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [BITS-1:0] set_i,
  input  logic [BITS-1:0] clr_i,
  output logic [BITS-1:0] pend_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_o <= '0;
    else        pend_o <= (pend_o & ~clr_i) | set_i;
  end

  for (genvar k = 0; k < BITS; k++) begin : g_chk
    AST_SET_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
      set_i[k] |=> pend_o[k]); // R10
    AST_CLR_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i[k] && !set_i[k]) |=> !pend_o[k]); // R9
    AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_i[k] && !set_i[k]) |=> $stable(pend_o[k])); // R8
  end

endmodule

// File: rtl/sgi_trigger.sv
module sgi_trigger
  import sgi_pkg::*;
#(
  parameter int NUM_CPU = 4,
  parameter int NUM_ID  = 16,
  parameter int CPU_W   = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en_i,
  input  logic [CPU_W-1:0]          wr_cpu_i,
  input  logic [31:0]               wr_data_i,
  input  logic [NUM_CPU-1:0]        ack_vld_i,
  input  logic [NUM_CPU*NUM_W-1:0]  ack_id_i,
  output logic [NUM_CPU*NUM_ID-1:0] pend_o
);

  localparam int BITS = NUM_CPU * NUM_ID;

  logic [NUM_CPU-1:0] dest;
  logic [NUM_W-1:0]   num;
  logic               fire;
  logic [BITS-1:0]    set_vec;
  logic [BITS-1:0]    clr_vec;

  sgi_route_dec #(.NUM_CPU(NUM_CPU), .CPU_W(CPU_W)) u_dec (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en_i   (wr_en_i),
    .wr_cpu_i  (wr_cpu_i),
    .wr_data_i (wr_data_i),
    .dest_o    (dest),
    .num_o     (num),
    .fire_o    (fire)
  );

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
    for (genvar n = 0; n < NUM_ID; n++) begin : g_num
      assign set_vec[c*NUM_ID+n] = fire && dest[c] && (num == NUM_W'(n));
      assign clr_vec[c*NUM_ID+n] = ack_vld_i[c] &&
                                   (ack_id_i[c*NUM_W +: NUM_W] == NUM_W'(n));
    end
  end

  sgi_pend_bank #(.BITS(BITS)) u_bank (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (set_vec),
    .clr_i  (clr_vec),
    .pend_o (pend_o)
  );

  AST_ONE_NUM_PER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> ($countones(set_vec) == $countones(dest))); // R2

endmodule

// File: tb/sim_sgi_trigger.sv
module sim_sgi_trigger;

  localparam int NC = 4;
  localparam int NI = 16;
  localparam int CW = 2;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            wr_en = 1'b0;
  logic [CW-1:0]   wr_cpu = '0;
  logic [31:0]     wr_data = '0;
  logic [NC-1:0]   ack_vld = '0;
  logic [NC*4-1:0] ack_id = '0;
  logic [NC*NI-1:0] pend;
  logic [NC*NI-1:0] model;

  int checks = 0;
  int fails = 0;

  always #5 clk = ~clk;

  sgi_trigger #(.NUM_CPU(NC), .NUM_ID(NI)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_cpu_i(wr_cpu),
    .wr_data_i(wr_data), .ack_vld_i(ack_vld), .ack_id_i(ack_id), .pend_o(pend)
  );

  function automatic logic [31:0] mk_word(int num, int map, int mode, logic junk);
    logic [31:0] w;
    w = (mode << 24) + (map << 16) + num;
    if (junk) w = w | 32'hFC00_FFF0;
    return w;
  endfunction

  function automatic bit hits(int writer, int mode, int map, int c);
    if (mode == 0) return ((map >> c) & 1) == 1;
    if (mode == 1) return c != writer;
    if (mode == 2) return c == writer;
    return 1'b0;
  endfunction

  task automatic check(string tag, string what);
    checks++;
    if (pend !== model) begin
      fails++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, pend, model);
    end
  endtask

  task automatic step(logic we, int writer, logic [31:0] w, logic [NC-1:0] av, logic [NC*4-1:0] ai);
    @(negedge clk);
    wr_en = we; wr_cpu = CW'(writer); wr_data = w; ack_vld = av; ack_id = ai;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0; ack_vld = '0;
    for (int c = 0; c < NC; c++)
      if (av[c]) model[c*NI + int'(ai[c*4 +: 4])] = 1'b0;
    if (we)
      for (int c = 0; c < NC; c++)
        if (hits(writer, int'(w[25:24]), int'(w[23:16]), c)) model[c*NI + int'(w[3:0])] = 1'b1;
  endtask

  task automatic clear_all();
    for (int n = 0; n < NI; n++)
      step(1'b0, 0, 32'h0, '1, {NC{4'(n)}});
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int maps[4];
    maps = '{8'h00, 8'h05, 8'hA3, 8'hF0};
    model = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "reset state");

    // R2 R3 R4 R5 R6 R7 R11: sweep writers, modes, bitmaps
    for (int w = 0; w < NC; w++)
      for (int m = 0; m < 4; m++)
        for (int t = 0; t < 4; t++) begin
          int n;
          n = (w * 5 + m * 3 + t * 7) % NI;
          step(1'b1, w, mk_word(n, maps[t], m, t[0]), '0, '0);
          if (m == 3) check("R6", "reserved mode");
          else if (m == 0 && (maps[t] & 8'h0F) == 0) check("R7", "empty list");
          else if (m == 0) check("R3", "list mode");
          else if (m == 1) check("R4", "others mode");
          else check("R5", "self mode");
          if (t[0]) check("R11", "junk bits");
          clear_all();
          check("R9", "full clear");
        end

    // R8: accumulate, repeat write, idle hold
    step(1'b1, 1, mk_word(7, 8'h0F, 0, 0), '0, '0);
    step(1'b1, 2, mk_word(7, 8'h00, 1, 0), '0, '0);
    check("R8", "repeat write stays set");
    step(1'b1, 3, mk_word(12, 8'h00, 2, 0), '0, '0);
    repeat (5) step(1'b0, 0, 32'h0, '0, '0);
    check("R8", "idle hold");

    // R9: clear a single bit only
    step(1'b0, 0, 32'h0, 4'b0100, 16'h0700);
    check("R9", "single clear");
    step(1'b0, 0, 32'h0, 4'b1000, 16'h5000);
    check("R9", "clear of idle number");

    // R10: set and clear on same bit, and on different CPUs
    step(1'b1, 0, mk_word(7, 8'h02, 0, 0), 4'b0010, 16'h0070);
    check("R10", "set wins over clear");
    step(1'b1, 0, mk_word(9, 8'h04, 0, 0), 4'b0011, 16'h0077);
    check("R10", "clear one cpu, set another");

    clear_all();
    check("R9", "final clear");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule